// File: doc/BRIEF.md
# UART Baud Rate Generator with Divisor Latch

This block produces the timing enables for an asynchronous serial port. It owns the line control byte, a 15-bit rate divisor and a reference clock select bit. It turns a chosen reference clock enable into two pulses. One is a tick at sixteen times the bit rate, used for receive oversampling. The other is a tick at the bit rate itself.

Software reaches the divisor through the same two byte offsets that normally carry the data path and the interrupt-enable register. A latch-access bit in the line control byte switches between the two views. While that bit is clear, the block only decodes accesses and forwards them as strobes to its neighbours, which hold the transmit buffer, the receive buffer and the interrupt-enable register. While the bit is set, the same offsets read and write the divisor bytes.

The top bit of the high divisor byte picks the reference: the slow 1.8432 MHz enable or the fast 48 MHz enable. The remaining 15 bits divide that reference. The resulting bit rate is reference / (16 * divisor), so software loads round(reference / (16 * baud)).

Top module: `uart_baud_gen`

## Requirements
- R1: After reset, both divisor bytes and the whole line control byte (offset 3) read as zero, and neither tick output pulses.
- R2: While line control bit 7 is 1, a write to offset 0 stores the divisor low byte and a write to offset 1 stores the divisor high byte. Reads of those offsets return the stored bytes. No neighbour strobe fires.
- R3: While line control bit 7 is 0, the block forwards accesses and leaves the divisor unchanged. A write to offset 0 raises `thr_we`. A read of offset 0 raises `rx_re` and returns `rx_data_i`. A write to offset 1 raises `ier_we`. A read of offset 1 returns `ier_rdata_i`. These strobes are combinational in the access cycle.
- R4: A write to offset 3 stores all 8 bits of the line control byte, and a read of offset 3 returns them. Changing only bit 7 leaves bits 6:0 as written.
- R5: High divisor byte bit 7 selects the reference enable: 0 selects `ref_slow_en` and 1 selects `ref_fast_en`. The unselected enable has no effect on the ticks.
- R6: With divisor D = {high[6:0], low} nonzero, `tick16_o` is a single-cycle pulse after every D cycles in which the selected enable is high. The pulse appears in the cycle after the enable that completes the count.
- R7: With D = 0, `tick16_o` and `tick_bit_o` never pulse.
- R8: A write to either divisor byte restarts both counters. An enable in the write cycle is not counted, and the first pulse follows D counted enables under the new settings.
- R9: `tick_bit_o` pulses together with every 16th `tick16_o` pulse counted from the last restart.
- R10: Reads of offsets other than 0, 1 and 3, and cycles without a read, return zero on `bus_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| rx_data_i | input | 8 | Receive buffer byte from neighbour |
| ier_rdata_i | input | 8 | Interrupt-enable byte from neighbour |
| thr_we | output | 1 | Write to transmit buffer |
| rx_re | output | 1 | Read of receive buffer |
| ier_we | output | 1 | Write to interrupt-enable register |
| lcr_o | output | 8 | Line control byte |
| ref_slow_en | input | 1 | Slow reference clock enable |
| ref_fast_en | input | 1 | Fast reference clock enable |
| tick16_o | output | 1 | Oversampling tick |
| tick_bit_o | output | 1 | Bit-rate tick |

## Verification
The bench builds the block with its default parameters: offsets 0, 1 and 3, latch-access bit 7 and an oversampling ratio of 16. With a ratio of 16, the bit-rate tick appears within a few hundred cycles for small divisors. Random divisors of 0 to 7 therefore reach many counter wrap-arounds, restarts in the middle of a count and reference switches. A directed divisor of 300 exercises the high byte carrying into the 15-bit count.

// File: rtl/uart_bg_pkg.sv
package uart_bg_pkg;
    localparam int BYTE_W = 8;

    typedef struct packed {
        logic [BYTE_W-1:0] lo;
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] lcr;
    } bg_regs_t;
endpackage

// File: rtl/uart_bg_regs.sv
module uart_bg_regs
    import uart_bg_pkg::*;
#(
    parameter int ADDR_W    = 3,
    parameter int OFS_LO    = 0,
    parameter int OFS_HI    = 1,
    parameter int OFS_LCR   = 3,
    parameter int LATCH_BIT = 7,
    localparam int DIV_W    = 2*BYTE_W-1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BYTE_W-1:0] bus_wdata,
    input  logic [BYTE_W-1:0] rx_data_i,
    input  logic [BYTE_W-1:0] ier_rdata_i,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic              thr_we,
    output logic              rx_re,
    output logic              ier_we,
    output logic [BYTE_W-1:0] lcr_q,
    output logic [DIV_W-1:0]  div_q,
    output logic              sel_q,
    output logic [DIV_W-1:0]  div_nxt,
    output logic              reload
);
    bg_regs_t st_d, st_q;
    logic hit_lo, hit_hi, hit_lcr, latch;

    always_comb begin
        st_d      = st_q;
        reload    = 1'b0;
        thr_we    = 1'b0;
        rx_re     = 1'b0;
        ier_we    = 1'b0;
        bus_rdata = '0;
        hit_lo    = (bus_addr == ADDR_W'(OFS_LO));
        hit_hi    = (bus_addr == ADDR_W'(OFS_HI));
        hit_lcr   = (bus_addr == ADDR_W'(OFS_LCR));
        latch     = st_q.lcr[LATCH_BIT];
        if (bus_wr) begin
            if (hit_lcr) st_d.lcr = bus_wdata;
            if (hit_lo) begin
                if (latch) begin
                    st_d.lo = bus_wdata;
                    reload  = 1'b1;
                end else begin
                    thr_we = 1'b1;
                end
            end
            if (hit_hi) begin
                if (latch) begin
                    st_d.hi = bus_wdata;
                    reload  = 1'b1;
                end else begin
                    ier_we = 1'b1;
                end
            end
        end
        if (bus_rd) begin
            if (hit_lcr) bus_rdata = st_q.lcr;
            if (hit_lo) begin
                if (latch) begin
                    bus_rdata = st_q.lo;
                end else begin
                    bus_rdata = rx_data_i;
                    rx_re     = 1'b1;
                end
            end
            if (hit_hi) bus_rdata = latch ? st_q.hi : ier_rdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lcr_q   = st_q.lcr;
    assign div_q   = {st_q.hi[BYTE_W-2:0], st_q.lo};
    assign sel_q   = st_q.hi[BYTE_W-1];
    assign div_nxt = {st_d.hi[BYTE_W-2:0], st_d.lo};
endmodule

// File: rtl/uart_bg_presc.sv
module uart_bg_presc #(
    parameter int DIV_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_en,
    input  logic             reload,
    input  logic [DIV_W-1:0] div_cur,
    input  logic [DIV_W-1:0] div_nxt,
    output logic             fire,
    output logic             tick_q
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             tick;
    } presc_t;

    presc_t st_d, st_q;
    logic   div_live;

    always_comb begin
        st_d     = st_q;
        div_live = (div_cur != '0);
        fire     = ref_en && div_live && (st_q.cnt == '0) && !reload;
        if (reload) begin
            st_d.cnt = (div_nxt == '0) ? '0 : div_nxt - 1'b1;
        end else if (ref_en && div_live) begin
            st_d.cnt = (st_q.cnt == '0) ? div_cur - 1'b1 : st_q.cnt - 1'b1;
        end
        st_d.tick = fire;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick_q = st_q.tick;
endmodule

// File: rtl/uart_bg_bitdiv.sv
module uart_bg_bitdiv #(
    parameter int RATIO = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic clear,
    output logic tick_q
);
    generate
        if (RATIO <= 1) begin : g_pass
            logic bit_d, bit_q;
            always_comb bit_d = fire && !clear;
            always_ff @(posedge clk) begin
                if (!rst_n) bit_q <= 1'b0;
                else        bit_q <= bit_d;
            end
            assign tick_q = bit_q;
        end else begin : g_count
            localparam int CW = $clog2(RATIO);
            typedef struct packed {
                logic [CW-1:0] cnt;
                logic          tick;
            } bdiv_t;
            bdiv_t st_d, st_q;
            logic  wrap;
            always_comb begin
                st_d      = st_q;
                wrap      = (st_q.cnt == CW'(RATIO-1));
                st_d.tick = fire && wrap && !clear;
                if (clear)     st_d.cnt = '0;
                else if (fire) st_d.cnt = wrap ? '0 : st_q.cnt + 1'b1;
            end
            always_ff @(posedge clk) begin
                if (!rst_n) st_q <= '0;
                else        st_q <= st_d;
            end
            assign tick_q = st_q.tick;
        end
    endgenerate
endmodule

// File: rtl/uart_baud_gen.sv
module uart_baud_gen
    import uart_bg_pkg::*;
#(
    parameter int ADDR_W     = 3,
    parameter int OFS_LO     = 0,
    parameter int OFS_HI     = 1,
    parameter int OFS_LCR    = 3,
    parameter int LATCH_BIT  = 7,
    parameter int OVERSAMPLE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic [BYTE_W-1:0] rx_data_i,
    input  logic [BYTE_W-1:0] ier_rdata_i,
    output logic              thr_we,
    output logic              rx_re,
    output logic              ier_we,
    output logic [BYTE_W-1:0] lcr_o,
    input  logic              ref_slow_en,
    input  logic              ref_fast_en,
    output logic              tick16_o,
    output logic              tick_bit_o
);
    localparam int DIV_W = 2*BYTE_W-1;

    logic [DIV_W-1:0] div_cur, div_nxt;
    logic             sel_q, sel_en, reload, fire;

    uart_bg_regs #(
        .ADDR_W(ADDR_W), .OFS_LO(OFS_LO), .OFS_HI(OFS_HI),
        .OFS_LCR(OFS_LCR), .LATCH_BIT(LATCH_BIT)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .rx_data_i(rx_data_i),
        .ier_rdata_i(ier_rdata_i), .bus_rdata(bus_rdata), .thr_we(thr_we),
        .rx_re(rx_re), .ier_we(ier_we), .lcr_q(lcr_o), .div_q(div_cur),
        .sel_q(sel_q), .div_nxt(div_nxt), .reload(reload)
    );

    assign sel_en = sel_q ? ref_fast_en : ref_slow_en;

    uart_bg_presc #(.DIV_W(DIV_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .ref_en(sel_en), .reload(reload),
        .div_cur(div_cur), .div_nxt(div_nxt), .fire(fire), .tick_q(tick16_o)
    );

    uart_bg_bitdiv #(.RATIO(OVERSAMPLE)) u_bitdiv (
        .clk(clk), .rst_n(rst_n), .fire(fire), .clear(reload),
        .tick_q(tick_bit_o)
    );
endmodule

// File: rtl/uart_baud_gen_chk.sv
module uart_baud_gen_chk #(
    parameter int DIV_W = 15
) (
    input logic             clk,
    input logic             rst_n,
    input logic [7:0]       lcr,
    input logic             thr_we,
    input logic             rx_re,
    input logic             ier_we,
    input logic [DIV_W-1:0] div_cur,
    input logic             reload,
    input logic             sel_en,
    input logic             tick16,
    input logic             tick_bit
);
    // R7
    zero_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (div_cur == '0 && !reload) |=> !tick16);
    // R9
    bit_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_bit |-> tick16);
    // R5
    tick_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick16 |-> $past(sel_en));
    // R8
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> !tick16);
    // R3
    alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_we || rx_re || ier_we) |-> !lcr[7]);
    // R6
    pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick16 && div_cur > 1) |=> !tick16);
endmodule

bind uart_baud_gen uart_baud_gen_chk u_chk (
    .clk(clk), .rst_n(rst_n), .lcr(lcr_o), .thr_we(thr_we), .rx_re(rx_re),
    .ier_we(ier_we), .div_cur(div_cur), .reload(reload), .sel_en(sel_en),
    .tick16(tick16_o), .tick_bit(tick_bit_o)
);

// File: tb/uart_baud_gen_tb.sv
module uart_baud_gen_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic [7:0] rx_data_i = 8'hA5, ier_rdata_i = 8'h3C;
    logic       thr_we, rx_re, ier_we;
    logic [7:0] lcr_o;
    logic       ref_slow_en = 1'b0, ref_fast_en = 1'b0;
    logic       tick16_o, tick_bit_o;

    int n_chk = 0, n_fail = 0;
    logic [7:0] m_lo = 0, m_hi = 0, m_lcr = 0;
    int m_cnt = 0, m_sub = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_baud_gen u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_data_i(rx_data_i), .ier_rdata_i(ier_rdata_i), .thr_we(thr_we),
        .rx_re(rx_re), .ier_we(ier_we), .lcr_o(lcr_o),
        .ref_slow_en(ref_slow_en), .ref_fast_en(ref_fast_en),
        .tick16_o(tick16_o), .tick_bit_o(tick_bit_o)
    );

    function automatic int div_of();
        return {m_hi[6:0], m_lo};
    endfunction

    function automatic logic [7:0] exp_rdata(input logic [2:0] a);
        if (a == 3) return m_lcr;
        if (a == 0) return m_lcr[7] ? m_lo : rx_data_i;
        if (a == 1) return m_lcr[7] ? m_hi : ier_rdata_i;
        return 8'h00;
    endfunction

    function automatic string read_req(input logic [2:0] a);
        if (a == 3) return "R4";
        if (a > 1)  return "R10";
        return m_lcr[7] ? "R2" : "R3";
    endfunction

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic do_cycle(input logic wr, input logic rd, input logic [2:0] a,
                            input logic [7:0] wd, input logic slow, input logic fast,
                            input string tag);
        logic reload, en, e16, eb;
        int d;
        @(negedge clk);
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd;
        ref_slow_en = slow; ref_fast_en = fast;
        #1;
        chk(bus_rdata, rd ? exp_rdata(a) : 8'h00, rd ? read_req(a) : "R10 idle read data");
        chk({7'd0, thr_we}, {7'd0, wr && a == 0 && !m_lcr[7]}, "R3 thr_we");
        chk({7'd0, rx_re},  {7'd0, rd && a == 0 && !m_lcr[7]}, "R3 rx_re");
        chk({7'd0, ier_we}, {7'd0, wr && a == 1 && !m_lcr[7]}, "R3 ier_we");
        @(posedge clk);
        #1;
        reload = wr && m_lcr[7] && (a == 0 || a == 1);
        e16 = 0; eb = 0;
        if (reload) begin
            if (a == 0) m_lo = wd; else m_hi = wd;
            m_cnt = 0; m_sub = 0;
        end else begin
            en = m_hi[7] ? fast : slow;
            d = div_of();
            if (en && d != 0) begin
                m_cnt++;
                if (m_cnt == d) begin
                    e16 = 1; m_cnt = 0; m_sub++;
                    if (m_sub == 16) begin eb = 1; m_sub = 0; end
                end
            end
        end
        if (wr && a == 3) m_lcr = wd;
        chk({7'd0, tick16_o}, {7'd0, e16}, {tag, " tick16"});
        chk({7'd0, tick_bit_o}, {7'd0, eb}, "R9 tick_bit");
        chk(lcr_o, m_lcr, "R4 line control");
    endtask

    task automatic idle(input int n, input logic slow, input logic fast, input string tag);
        for (int i = 0; i < n; i++) do_cycle(0, 0, 3'd0, 8'h00, slow, fast, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [2:0] ra;
        logic [7:0] rw;
        int r;
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(lcr_o, 8'h00, "R1 line control after reset");
        chk({7'd0, tick16_o}, 8'h00, "R1 tick16 after reset");
        do_cycle(0, 1, 3'd3, 8'h00, 1, 1, "R1");
        do_cycle(1, 0, 3'd3, 8'h83, 1, 1, "R7");
        do_cycle(0, 1, 3'd0, 8'h00, 1, 1, "R1");
        do_cycle(0, 1, 3'd1, 8'h00, 1, 1, "R1");
        idle(20, 1, 1, "R7");
        // R2 and R6: divisor 5 on slow reference
        do_cycle(1, 0, 3'd0, 8'h05, 1, 1, "R8");
        do_cycle(0, 1, 3'd0, 8'h00, 1, 0, "R2");
        do_cycle(0, 1, 3'd1, 8'h00, 1, 0, "R2");
        idle(100, 1, 0, "R6");
        // R5: select fast reference, slow ignored
        do_cycle(1, 0, 3'd1, 8'h80, 1, 1, "R8");
        idle(30, 1, 0, "R5");
        idle(60, 0, 1, "R5");
        // R4 and R3: clear latch bit, forward accesses, divisor kept
        do_cycle(1, 0, 3'd3, 8'h03, 0, 1, "R6");
        do_cycle(0, 1, 3'd3, 8'h00, 0, 1, "R4");
        do_cycle(1, 0, 3'd0, 8'h77, 0, 1, "R3");
        do_cycle(1, 0, 3'd1, 8'h0F, 0, 1, "R3");
        do_cycle(0, 1, 3'd0, 8'h00, 0, 1, "R3");
        do_cycle(0, 1, 3'd1, 8'h00, 0, 1, "R3");
        do_cycle(1, 0, 3'd3, 8'h83, 0, 1, "R6");
        do_cycle(0, 1, 3'd0, 8'h00, 0, 1, "R3");
        do_cycle(0, 1, 3'd2, 8'h00, 0, 1, "R10");
        // R8: restart in the middle of a count
        idle(3, 0, 1, "R6");
        do_cycle(1, 0, 3'd0, 8'h03, 0, 1, "R8");
        idle(10, 0, 1, "R8");
        // R7: zero divisor
        do_cycle(1, 0, 3'd0, 8'h00, 1, 1, "R8");
        do_cycle(1, 0, 3'd1, 8'h00, 1, 1, "R8");
        idle(50, 1, 1, "R7");
        // R6 with high byte: divisor 300
        do_cycle(1, 0, 3'd1, 8'h01, 1, 1, "R8");
        do_cycle(1, 0, 3'd0, 8'h2C, 1, 1, "R8");
        idle(4900, 1, 1, "R6");
        // constrained random
        for (int i = 0; i < 3000; i++) begin
            r  = $urandom_range(0, 99);
            ra = 3'($urandom_range(0, 4));
            if (ra == 0)      rw = 8'($urandom_range(0, 7));
            else if (ra == 1) rw = {1'($urandom_range(0, 1)), 7'd0};
            else              rw = 8'($urandom);
            do_cycle(r < 6, r >= 6 && r < 14, ra, rw,
                     $urandom_range(0, 2) == 0, $urandom_range(0, 1) == 0, "R6");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule